// File: doc/BRIEF.md
# Multi-Core Interrupt Router

This block steers 32 level-sensitive interrupt sources to 4 cores, each of which has 4 interrupt lines, for 16 outputs in all. Output index `4*c + y` belongs to line `y` of core `c`. Every source owns a one-byte route entry. The low four bits of the entry select cores and the high four bits select lines, so one source can reach several cores and several lines at the same time. A global enable mask gates all sources. Software changes the mask through a set register and a clear register, so it never needs a read-modify-write.

Software reads an aggregate status word and one status word per core. The status word is the source levels ANDed with the mask. A core's status word is the enabled active sources whose route entry selects that core. Output `4*c + y` is high when core `c` has any status bit set and, at the same time, any enabled active source has line bit `y` set in its route entry. The two conditions may be met by different sources. Status and outputs are registered. The register bus is a simple synchronous request port with a size flag, and read data comes back one cycle after the request.

Top module: `irq_router`

## Requirements
- R1: After reset, the enable mask, all 32 route entries, all status words and all 16 outputs read or drive zero.
- R2: A byte write to offset `n` (0x00 to 0x1F) stores `wdata[7:0]` as the route entry of source `n`. Bits [3:0] select cores 0 to 3 and bits [7:4] select lines 0 to 3. A byte read at `n` returns the entry in `rdata[7:0]` with the upper bits zero.
- R3: A word write to 0x28 ORs the write data into the enable mask. The mask reads back at 0x24, and bit `i` of the mask enables source `i`.
- R4: A word write to 0x2C clears each mask bit that is 1 in the write data and leaves the other mask bits unchanged.
- R5: The status word at 0x20 equals the source levels ANDed with the mask.
- R6: The status word of core `c`, read at `0x40 + 8*c`, holds the enabled active sources whose route bit `c` is set. Writes to these offsets change nothing.
- R7: Output `4*c + y` is high exactly when core `c`'s status word is non-zero and some enabled active source has route bit `4+y` set. The source meeting the core condition need not be the one meeting the line condition.
- R8: Only aligned word accesses reach 0x20 and above, and only byte accesses reach the route entries. A misaligned access, a wrong-size access, or a byte access at 0x20 and above is ignored on write and returns zero on read.
- R9: Reads of 0x28, 0x2C, the gaps between core status words, and 0x60 to 0x7F return zero.
- R10: Read data appears on `bus_rdata` in the cycle after the request and is zero in any cycle that follows no read.
- R11: A change on the sources shows in status and outputs one clock edge later. A register write takes effect at its own edge and shows in status and outputs at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Level-sensitive sources, synchronous to clk |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_byte | input | 1 | 1 = byte access, 0 = word access |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| irq_out | output | 16 | Output 4*c+y drives line y of core c |

## Verification
A change on the sources is due on status and outputs after one rising edge. A register write is due two edges after the write request is driven: one edge stores the register and the next updates status and outputs. Read data is due at the edge after the request. The bench drives every input at a falling edge and samples at a later falling edge. It waits at least two edges after any write before comparing outputs. It also has one directed case that samples exactly one edge after a source change, to confirm the single-cycle latency.

// File: rtl/irqr_pkg.sv
// Package for the interrupt router: register offsets, bus decode type and
// the decode function. Assumes a 7-bit byte address and at most 32
// sources and 4 cores, so route and core indices fit the fields below.
package irqr_pkg;

    localparam int ADDR_W      = 7;
    localparam int RIDX_W      = 5;
    localparam int CIDX_W      = 2;

    localparam logic [ADDR_W-1:0] OFF_STATUS = 7'h20;
    localparam logic [ADDR_W-1:0] OFF_MASK   = 7'h24;
    localparam logic [ADDR_W-1:0] OFF_SET    = 7'h28;
    localparam logic [ADDR_W-1:0] OFF_CLR    = 7'h2C;

    typedef struct packed {
        logic              route;
        logic              status;
        logic              mask_rd;
        logic              mask_set;
        logic              mask_clr;
        logic              core;
        logic [RIDX_W-1:0] route_idx;
        logic [CIDX_W-1:0] core_idx;
    } dec_t;

    // Map an offset and access size onto one register select (or none).
    function automatic dec_t decode(input logic [ADDR_W-1:0] a,
                                    input logic is_byte,
                                    input int n_src,
                                    input int n_core);
        dec_t d;
        d = '0;
        if (is_byte) begin
            if (a[6:5] == 2'b00 && int'(a[4:0]) < n_src) begin
                d.route     = 1'b1;
                d.route_idx = a[4:0];
            end
        end else if (a[1:0] == 2'b00) begin
            d.status   = (a == OFF_STATUS);
            d.mask_rd  = (a == OFF_MASK);
            d.mask_set = (a == OFF_SET);
            d.mask_clr = (a == OFF_CLR);
            if (a[6:5] == 2'b10 && a[2:0] == 3'b000 && int'(a[4:3]) < n_core) begin
                d.core     = 1'b1;
                d.core_idx = a[4:3];
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/irqr_regfile.sv
// Route entries and the enable mask. Takes decoded write strobes from the
// top and holds no status. Assumes at most one strobe is active per cycle.
module irqr_regfile #(
    parameter int N_SRC  = 32,
    parameter int N_CORE = 4,
    parameter int N_LINE = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rt_wr,
    input  logic [irqr_pkg::RIDX_W-1:0]   rt_idx,
    input  logic                          set_wr,
    input  logic                          clr_wr,
    input  logic [N_SRC-1:0]              wdata,
    output logic [N_SRC*(N_CORE+N_LINE)-1:0] route_flat,
    output logic [N_SRC-1:0]              mask_q
);

    localparam int RW = N_CORE + N_LINE;

    // One route entry register per source.
    for (genvar i = 0; i < N_SRC; i++) begin : g_route
        // Store the entry on a byte write addressed to this source.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                route_flat[i*RW +: RW] <= '0;
            end else if (rt_wr && int'(rt_idx) == i) begin
                route_flat[i*RW +: RW] <= wdata[RW-1:0];
            end
        end
    end

    // Enable mask: OR in on a set write, knock out bits on a clear write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (set_wr) begin
            mask_q <= mask_q | wdata;
        end else if (clr_wr) begin
            mask_q <= mask_q & ~wdata;
        end
    end

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> mask_q == ($past(mask_q) | $past(wdata)));

    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> mask_q == ($past(mask_q) & ~$past(wdata)));

    // R2
    route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rt_wr |=> $stable(route_flat));

endmodule

// File: rtl/irqr_fanout.sv
// Computes the status word, the per-core status words and the outputs from
// the source levels, the mask and the route entries, and registers them.
// Assumes the sources are already synchronous to clk.
module irqr_fanout #(
    parameter int N_SRC  = 32,
    parameter int N_CORE = 4,
    parameter int N_LINE = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_SRC-1:0]                  pins,
    input  logic [N_SRC-1:0]                  mask_q,
    input  logic [N_SRC*(N_CORE+N_LINE)-1:0]  route_flat,
    output logic [N_SRC-1:0]                  status_q,
    output logic [N_CORE*N_SRC-1:0]           core_q,
    output logic [N_CORE*N_LINE-1:0]          irq_q
);

    localparam int RW   = N_CORE + N_LINE;
    localparam int NOUT = N_CORE * N_LINE;

    logic [N_SRC-1:0]       status_d;
    logic [N_CORE*N_SRC-1:0] core_d;
    logic [N_LINE-1:0]      line_any;
    logic [NOUT-1:0]        irq_d;

    // Gate the levels with the mask.
    always_comb status_d = pins & mask_q;

    // One column of sources per core and per line.
    for (genvar c = 0; c < N_CORE; c++) begin : g_core
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            // Source i counts for core c if active and routed there.
            always_comb core_d[c*N_SRC + i] = status_d[i] & route_flat[i*RW + c];
        end
    end

    for (genvar y = 0; y < N_LINE; y++) begin : g_line
        logic [N_SRC-1:0] col;
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            // Source i counts for line y if active and routed there.
            always_comb col[i] = status_d[i] & route_flat[i*RW + N_CORE + y];
        end
        // Any enabled active source selecting this line.
        always_comb line_any[y] = |col;
    end

    for (genvar c = 0; c < N_CORE; c++) begin : g_out_c
        for (genvar y = 0; y < N_LINE; y++) begin : g_out_y
            // Core condition and line condition met independently.
            always_comb irq_d[c*N_LINE + y] = (|core_d[c*N_SRC +: N_SRC]) & line_any[y];
        end
    end

    // Register all results together so they change on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            core_q   <= '0;
            irq_q    <= '0;
        end else begin
            status_q <= status_d;
            core_q   <= core_d;
            irq_q    <= irq_d;
        end
    end

    // R5
    status_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_q) |-> ((status_q & ~$past(pins)) == '0));

    for (genvar c = 0; c < N_CORE; c++) begin : g_chk
        // R6
        core_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (core_q[c*N_SRC +: N_SRC] & ~status_q) == '0);
        for (genvar y = 0; y < N_LINE; y++) begin : g_chk_y
            // R7
            out_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_q[c*N_LINE + y] |-> (|core_q[c*N_SRC +: N_SRC]));
        end
    end

endmodule

// File: rtl/irqr_readback.sv
// Read multiplexer with one register stage. Takes decoded read selects
// from the top; a cycle without a read returns zero.
module irqr_readback #(
    parameter int N_SRC  = 32,
    parameter int N_CORE = 4,
    parameter int N_LINE = 4,
    parameter int DW     = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_en,
    input  logic                              sel_route,
    input  logic [irqr_pkg::RIDX_W-1:0]       route_idx,
    input  logic                              sel_status,
    input  logic                              sel_mask,
    input  logic                              sel_core,
    input  logic [irqr_pkg::CIDX_W-1:0]       core_idx,
    input  logic [N_SRC*(N_CORE+N_LINE)-1:0]  route_flat,
    input  logic [N_SRC-1:0]                  mask_q,
    input  logic [N_SRC-1:0]                  status_q,
    input  logic [N_CORE*N_SRC-1:0]           core_q,
    output logic [DW-1:0]                     rdata_q
);

    localparam int RW = N_CORE + N_LINE;

    logic [DW-1:0] rd_d;

    // Pick the selected register; unmapped selections give zero.
    always_comb begin
        rd_d = '0;
        if (rd_en) begin
            if (sel_route) begin
                rd_d[RW-1:0] = route_flat[int'(route_idx)*RW +: RW];
            end else if (sel_status) begin
                rd_d[N_SRC-1:0] = status_q;
            end else if (sel_mask) begin
                rd_d[N_SRC-1:0] = mask_q;
            end else if (sel_core) begin
                rd_d[N_SRC-1:0] = core_q[int'(core_idx)*N_SRC +: N_SRC];
            end
        end
    end

    // Return the data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_d;
        end
    end

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata_q == '0);

endmodule

// File: rtl/irq_router.sv
// Top of the interrupt router. Decodes bus requests and connects the
// register file, the fanout logic and the read multiplexer. Assumes the
// sources and the bus are synchronous to clk.
module irq_router #(
    parameter int N_SRC  = 32,
    parameter int N_CORE = 4,
    parameter int N_LINE = 4,
    parameter int DW     = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_SRC-1:0]            irq_in,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [irqr_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]               bus_wdata,
    input  logic                        bus_byte,
    output logic [DW-1:0]               bus_rdata,
    output logic [N_CORE*N_LINE-1:0]    irq_out
);

    import irqr_pkg::*;

    localparam int RW   = N_CORE + N_LINE;
    localparam int NOUT = N_CORE * N_LINE;

    dec_t                   dec;
    logic                   wr_en;
    logic                   rd_en;
    logic [N_SRC*RW-1:0]    route_flat;
    logic [N_SRC-1:0]       mask_q;
    logic [N_SRC-1:0]       status_q;
    logic [N_CORE*N_SRC-1:0] core_q;
    logic [NOUT-1:0]        irq_q;

    // Decode the request into a single register select.
    always_comb begin
        dec   = decode(bus_addr, bus_byte, N_SRC, N_CORE);
        wr_en = bus_valid & bus_write;
        rd_en = bus_valid & ~bus_write;
    end

    irqr_regfile #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_LINE(N_LINE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rt_wr      (wr_en & dec.route),
        .rt_idx     (dec.route_idx),
        .set_wr     (wr_en & dec.mask_set),
        .clr_wr     (wr_en & dec.mask_clr),
        .wdata      (bus_wdata[N_SRC-1:0]),
        .route_flat (route_flat),
        .mask_q     (mask_q)
    );

    irqr_fanout #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_LINE(N_LINE)) u_fan (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins       (irq_in),
        .mask_q     (mask_q),
        .route_flat (route_flat),
        .status_q   (status_q),
        .core_q     (core_q),
        .irq_q      (irq_q)
    );

    irqr_readback #(.N_SRC(N_SRC), .N_CORE(N_CORE), .N_LINE(N_LINE), .DW(DW)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .sel_route  (dec.route),
        .route_idx  (dec.route_idx),
        .sel_status (dec.status),
        .sel_mask   (dec.mask_rd),
        .sel_core   (dec.core),
        .core_idx   (dec.core_idx),
        .route_flat (route_flat),
        .mask_q     (mask_q),
        .status_q   (status_q),
        .core_q     (core_q),
        .rdata_q    (bus_rdata)
    );

    // Drive the registered outputs.
    always_comb irq_out = irq_q;

    // R8
    misalign_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !bus_byte && bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);

    // R8
    misalign_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !bus_byte && bus_addr[1:0] != 2'b00) |=> $stable(mask_q));

    // R1
    no_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_q) |-> $past(|mask_q));

    // R7
    out_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |-> (|status_q));

endmodule

// File: tb/irq_router_test.sv
// Bench for irq_router: directed corner cases plus seeded random traffic,
// compared against a model built from the requirements.
module irq_router_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_in;
    logic        bus_valid;
    logic        bus_write;
    logic [6:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_byte;
    logic [31:0] bus_rdata;
    logic [15:0] irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [7:0]  route_m [32];
    logic [31:0] mask_m;

    irq_router uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_byte(bus_byte), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] e_status();
        return irq_in & mask_m;
    endfunction

    function automatic logic [31:0] e_core(input int c);
        logic [31:0] s, r;
        s = e_status();
        r = '0;
        for (int i = 0; i < 32; i++) r[i] = s[i] & route_m[i][c];
        return r;
    endfunction

    function automatic logic [15:0] e_out();
        logic [31:0] s;
        logic [3:0]  ln;
        logic [15:0] o;
        s  = e_status();
        ln = '0;
        for (int i = 0; i < 32; i++)
            for (int y = 0; y < 4; y++) if (s[i] && route_m[i][4+y]) ln[y] = 1'b1;
        o = '0;
        for (int c = 0; c < 4; c++)
            for (int y = 0; y < 4; y++) o[4*c+y] = (e_core(c) != 0) && ln[y];
        return o;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model of legal writes per R2, R3, R4, R6, R8.
    task automatic m_write(input logic [6:0] a, input logic [31:0] d, input logic b);
        if (b) begin
            if (a < 7'h20) route_m[a[4:0]] = d[7:0];
        end else if (a == 7'h28) mask_m = mask_m | d;
        else if (a == 7'h2C) mask_m = mask_m & ~d;
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic [31:0] d, input logic b);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_byte = b;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        m_write(a, d, b);
    endtask

    task automatic bus_rd(input logic [6:0] a, input logic b, input string tag,
                          input logic [31:0] exp);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_byte = b;
        @(negedge clk);
        bus_valid = 0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        settle();
        chk({tag, " R7 out"}, {16'h0, irq_out}, {16'h0, e_out()});
        bus_rd(7'h20, 0, {tag, " R5 status"}, e_status());
        for (int c = 0; c < 4; c++)
            bus_rd(7'(8'h40 + 8*c), 0, {tag, " R6 core"}, e_core(c));
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'd1234));
        for (int i = 0; i < 32; i++) route_m[i] = '0;
        mask_m = '0;
        rst_n = 0; irq_in = '0; bus_valid = 0; bus_write = 0;
        bus_addr = '0; bus_wdata = '0; bus_byte = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        irq_in = 32'hFFFF_FFFF;
        // R1: reset state, even with all sources high
        settle();
        chk("R1 out", {16'h0, irq_out}, 32'h0);
        bus_rd(7'h24, 0, "R1 mask", 32'h0);
        bus_rd(7'h20, 0, "R1 status", 32'h0);
        bus_rd(7'h07, 1, "R1 route", 32'h0);
        irq_in = '0;

        // R2: route write and readback
        bus_wr(7'h05, 32'hFFFF_FFA5, 1);
        bus_wr(7'h1F, 32'h0000_003C, 1);
        bus_rd(7'h05, 1, "R2 route5", 32'h0000_00A5);
        bus_rd(7'h1F, 1, "R2 route31", 32'h0000_003C);

        // R3 / R4: set and clear
        bus_wr(7'h28, 32'h0000_00F0, 0);
        bus_wr(7'h28, 32'h0000_0F00, 0);
        bus_rd(7'h24, 0, "R3 mask set", 32'h0000_0FF0);
        bus_wr(7'h2C, 32'h0000_0030, 0);
        bus_rd(7'h24, 0, "R4 mask clr", 32'h0000_0FC0);

        // R9: write-only and unmapped offsets read zero
        bus_rd(7'h28, 0, "R9 set rd", 32'h0);
        bus_rd(7'h2C, 0, "R9 clr rd", 32'h0);
        bus_rd(7'h44, 0, "R9 gap rd", 32'h0);
        bus_rd(7'h60, 0, "R9 hi rd", 32'h0);
        bus_rd(7'h7C, 0, "R9 top rd", 32'h0);

        // R8: wrong size or alignment
        bus_wr(7'h29, 32'hFFFF_FFFF, 0);
        bus_wr(7'h28, 32'hFFFF_FFFF, 1);
        bus_wr(7'h04, 32'hFFFF_FFFF, 0);
        bus_rd(7'h24, 0, "R8 mask unchanged", 32'h0000_0FC0);
        bus_rd(7'h04, 1, "R8 route unchanged", 32'h0);
        bus_rd(7'h25, 0, "R8 misaligned rd", 32'h0);
        bus_rd(7'h24, 1, "R8 byte rd", 32'h0);
        bus_rd(7'h05, 0, "R8 word rd route", 32'h0);

        // R7: cross-source AND; src 3 -> core0 only, src 9 -> line2 only
        bus_wr(7'h03, 32'h01, 1);
        bus_wr(7'h09, 32'h40, 1);
        bus_wr(7'h28, 32'h0000_0208, 0);
        irq_in = 32'h0000_0208;
        check_all("R7 cross");
        chk("R7 cross idx2", {31'h0, irq_out[2]}, 32'h1);
        irq_in = 32'h0000_0008;
        check_all("R7 core only");

        // R6: write to a core status changes nothing
        irq_in = 32'h0000_0208;
        bus_wr(7'h40, 32'hFFFF_FFFF, 0);
        bus_rd(7'h40, 0, "R6 core write ignored", 32'h0000_0008);

        // R11: source change seen after exactly one edge
        @(negedge clk);
        irq_in = 32'h0000_0008;
        @(negedge clk);
        chk("R11 src latency", {16'h0, irq_out}, 32'h0);
        irq_in = 32'h0000_0208;
        @(negedge clk);
        chk("R11 src latency up", {16'h0, irq_out}, 32'h0000_0004);

        // R10: rdata zero in a cycle after no read
        @(negedge clk);
        chk("R10 idle rdata", bus_rdata, 32'h0);

        // Random traffic
        for (int it = 0; it < 60; it++) begin
            for (int k = 0; k < 4; k++) begin
                case ($urandom_range(0, 4))
                    0: irq_in = $urandom();
                    1: bus_wr(7'($urandom_range(0, 31)), $urandom(), 1);
                    2: bus_wr(7'h28, $urandom() & $urandom(), 0);
                    3: bus_wr(7'h2C, $urandom() & $urandom(), 0);
                    default: bus_wr(7'($urandom_range(0, 127)) | 7'h1, $urandom(), 0);
                endcase
            end
            check_all("rand");
            r = 32'($urandom_range(0, 31));
            bus_rd(7'(r), 1, "R2 rand route", {24'h0, route_m[r[4:0]]});
            bus_rd(7'h24, 0, "R3 rand mask", mask_m);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule